// File: doc/BRIEF.md
# Shared Hardware Lock Bank

This block holds a bank of one-bit hardware locks that several processors use to take turns at peripherals they share. A master claims a lock by reading that lock's register. The read returns the state the lock had before the access, and the same access leaves the lock held. A master frees a lock by writing zero to the register.

The number of locks is fixed at build time. The bank reports its size to software through a size word. A second status word mirrors the state of the lowest 32 locks. Every master has its own single-cycle request port. A fixed-priority arbiter admits one access per cycle, so every test-and-claim is atomic with respect to all masters. A master that is not granted keeps its request up and is served in a later cycle.

Each lock is a two-state machine with the states `LK_FREE` and `LK_HELD`. It has two transitions:
- **take**: a granted read of the lock's register while the lock is in `LK_FREE`. The lock moves to `LK_HELD`.
- **release**: a granted write of zero to the lock's register while the lock is in `LK_HELD`. The lock moves to `LK_FREE`.

Every other access leaves the lock in its current state.

Top module: `spinlock_bank`

## Requirements
- R1: The size word at byte offset 0x000 returns the size code in bits 31:28 and zero in bits 27:0. Code 1, 2, 3 or 4 means 32, 64, 128 or 256 locks, so the lock count is 1 << (4 + code).
- R2: A granted read of lock i at byte offset 0x100 + 4*i returns 0 when the lock was free, and the lock is held afterwards.
- R3: A granted read of a lock that is already held returns 1, and the lock stays held.
- R4: A granted write of 0x00000000 to a lock register releases that lock.
- R5: Two kinds of write have no effect on any lock or on any read value: a write of a nonzero value to a lock register, and any write to offset 0x000 or 0x010.
- R6: The lock map word at byte offset 0x010 returns bit i = 1 exactly when lock i is held, for locks 0 to 31. Reading it changes no state.
- R7: Reads of the following addresses return 0 and change no lock state: any offset not named in R1, R2 or R6, any lock index at or above the configured count, and any address whose bits 1:0 are not zero.
- R8: At most one master is granted per cycle. A requesting master with the lowest index wins. When two masters read the same free lock in the same cycle, the lower index receives 0 and the other receives 1 in the following grant.
- R9: A granted read produces `rvalid_o` set for exactly the granted master, with `rdata_o` valid, in the cycle after the grant. A granted write produces no `rvalid_o`.
- R10: Reset returns every lock to the free state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_MASTERS | Per-master access request, held until granted |
| we_i | input | NUM_MASTERS | Per-master write enable (1 = write, 0 = read) |
| addr_i | input | NUM_MASTERS*ADDR_W | Per-master byte address, master m at bits m*ADDR_W upward |
| wdata_i | input | NUM_MASTERS*32 | Per-master write data, master m at bits m*32 upward |
| gnt_o | output | NUM_MASTERS | One-hot grant for the current cycle |
| rvalid_o | output | NUM_MASTERS | Read response valid, one cycle after a read grant |
| rdata_o | output | 32 | Read response data, shared by all masters |

## Verification
The properties assume three things about the masters:
- A master holds its request, address and data steady until it sees its grant.
- No request is raised while reset is asserted.
- An address points at the register it means.

The stimulus respects these assumptions. Single accesses go through a task that raises one request at a negative clock edge, waits for the grant and drops the request after the granting edge. Only the contention case raises two requests at once, and it keeps the losing master's request steady until that master is served. Expected values come from a bank model that the bench keeps in step with its own sequence of takes and releases. That sequence sweeps every lock of the 32-lock build and every lock index from 32 to 63 that lies beyond the configured count.

// File: rtl/spinlock_pkg.sv
`timescale 1ns/1ps
package spinlock_pkg;

    localparam int unsigned DATA_W         = 32;
    // Word offsets (byte offset >> 2) of the fixed registers.
    localparam int unsigned SIZE_WORD      = 0;    // byte 0x000
    localparam int unsigned MAP_WORD       = 4;    // byte 0x010
    localparam int unsigned LOCK_BASE_WORD = 64;   // byte 0x100
    localparam int unsigned MAP_BITS       = 32;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_LOCK_TAKE,
        ACC_LOCK_RELEASE,
        ACC_SIZE_READ,
        ACC_MAP_READ,
        ACC_VOID_READ,
        ACC_VOID_WRITE
    } acc_kind_e;

    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    function automatic logic [3:0] size_code(input int unsigned n);
        case (n)
            32:      return 4'd1;
            64:      return 4'd2;
            128:     return 4'd3;
            256:     return 4'd4;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/spin_arbiter.sv
`timescale 1ns/1ps
module spin_arbiter #(
    parameter int unsigned NUM_MASTERS = 2,
    localparam int unsigned MW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic [NUM_MASTERS-1:0] req_i,
    output logic [NUM_MASTERS-1:0] gnt_o,
    output logic [MW-1:0]          win_o,
    output logic                   any_o
);

    // Scan from the top down so that the lowest requesting index wins.
    always_comb begin
        gnt_o = '0;
        win_o = '0;
        for (int m = NUM_MASTERS - 1; m >= 0; m--) begin
            if (req_i[m]) begin
                gnt_o    = '0;
                gnt_o[m] = 1'b1;
                win_o    = MW'(m);
            end
        end
        any_o = |req_i;
    end

endmodule

// File: rtl/spin_decoder.sv
`timescale 1ns/1ps
module spin_decoder
    import spinlock_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned ADDR_W    = 12,
    localparam int unsigned IDX_W    = $clog2(NUM_LOCKS),
    localparam int unsigned WORD_W   = ADDR_W - 2
) (
    input  logic              valid_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output acc_kind_e         kind_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam logic [WORD_W-1:0] LOCK_LO = WORD_W'(LOCK_BASE_WORD);
    localparam logic [WORD_W-1:0] LOCK_HI = WORD_W'(LOCK_BASE_WORD + NUM_LOCKS);
    localparam logic [WORD_W-1:0] SIZE_W  = WORD_W'(SIZE_WORD);
    localparam logic [WORD_W-1:0] MAP_W   = WORD_W'(MAP_WORD);

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              in_locks;

    always_comb begin
        word     = addr_i[ADDR_W-1:2];
        aligned  = (addr_i[1:0] == 2'b00);
        in_locks = aligned && (word >= LOCK_LO) && (word < LOCK_HI);
        idx_o    = IDX_W'(word - LOCK_LO);
    end

    always_comb begin
        kind_o = ACC_NONE;
        if (valid_i) begin
            if (in_locks) begin
                if (!we_i)                kind_o = ACC_LOCK_TAKE;
                else if (wdata_i == '0)   kind_o = ACC_LOCK_RELEASE;
                else                      kind_o = ACC_VOID_WRITE;
            end else if (we_i) begin
                kind_o = ACC_VOID_WRITE;
            end else if (aligned && word == SIZE_W) begin
                kind_o = ACC_SIZE_READ;
            end else if (aligned && word == MAP_W) begin
                kind_o = ACC_MAP_READ;
            end else begin
                kind_o = ACC_VOID_READ;
            end
        end
    end

endmodule

// File: rtl/spin_lock_cell.sv
`timescale 1ns/1ps
module spin_lock_cell
    import spinlock_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic take_i,
    input  logic release_i,
    output logic held_o
);

    lock_state_e state_q;
    lock_state_e state_d;

    // Next state: take moves FREE->HELD, release moves HELD->FREE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_FREE: if (take_i)    state_d = LK_HELD;
            LK_HELD: if (release_i) state_d = LK_FREE;
            default:                state_d = LK_FREE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= LK_FREE;
        else         state_q <= state_d;
    end

    always_comb begin
        held_o = (state_q == LK_HELD);
    end

endmodule

// File: rtl/spinlock_bank.sv
`timescale 1ns/1ps
module spinlock_bank
    import spinlock_pkg::*;
#(
    parameter int unsigned NUM_LOCKS   = 32,
    parameter int unsigned NUM_MASTERS = 2,
    parameter int unsigned ADDR_W      = 12
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [NUM_MASTERS-1:0]        req_i,
    input  logic [NUM_MASTERS-1:0]        we_i,
    input  logic [NUM_MASTERS*ADDR_W-1:0] addr_i,
    input  logic [NUM_MASTERS*DATA_W-1:0] wdata_i,
    output logic [NUM_MASTERS-1:0]        gnt_o,
    output logic [NUM_MASTERS-1:0]        rvalid_o,
    output logic [DATA_W-1:0]             rdata_o
);

    localparam int unsigned IDX_W     = $clog2(NUM_LOCKS);
    localparam int unsigned MW        = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
    localparam logic [3:0]  SIZE_CODE = size_code(NUM_LOCKS);

    if (SIZE_CODE == 4'd0) begin : g_bad_size
        $error("NUM_LOCKS must be 32, 64, 128 or 256");
    end
    if ((LOCK_BASE_WORD + NUM_LOCKS) > (1 << (ADDR_W - 2))) begin : g_bad_addr
        $error("ADDR_W too small for the lock region");
    end

    logic [MW-1:0]           win;
    logic                    any_req;
    logic                    win_we;
    logic [ADDR_W-1:0]       win_addr;
    logic [DATA_W-1:0]       win_wdata;
    acc_kind_e               kind;
    logic [IDX_W-1:0]        idx;
    logic [NUM_LOCKS-1:0]    lock_held;
    logic [DATA_W-1:0]       rd_d;
    logic [NUM_MASTERS-1:0]  rvalid_q;
    logic [DATA_W-1:0]       rdata_q;

    spin_arbiter #(.NUM_MASTERS(NUM_MASTERS)) arb_i (
        .req_i (req_i),
        .gnt_o (gnt_o),
        .win_o (win),
        .any_o (any_req)
    );

    always_comb begin
        win_we    = we_i[win];
        win_addr  = addr_i[win*ADDR_W +: ADDR_W];
        win_wdata = wdata_i[win*DATA_W +: DATA_W];
    end

    spin_decoder #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) dec_i (
        .valid_i (any_req),
        .we_i    (win_we),
        .addr_i  (win_addr),
        .wdata_i (win_wdata),
        .kind_o  (kind),
        .idx_o   (idx)
    );

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
        logic take;
        logic rel;
        always_comb begin
            take = (kind == ACC_LOCK_TAKE)    && (idx == IDX_W'(i));
            rel  = (kind == ACC_LOCK_RELEASE) && (idx == IDX_W'(i));
        end
        spin_lock_cell cell_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .take_i    (take),
            .release_i (rel),
            .held_o    (lock_held[i])
        );
    end

    // Read value: the state before this access (old state for a take).
    always_comb begin
        rd_d = '0;
        unique case (kind)
            ACC_LOCK_TAKE: rd_d = {{(DATA_W-1){1'b0}}, lock_held[idx]};
            ACC_SIZE_READ: rd_d = {SIZE_CODE, {(DATA_W-4){1'b0}}};
            ACC_MAP_READ:  rd_d = lock_held[MAP_BITS-1:0];
            default:       rd_d = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rvalid_q <= '0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= gnt_o & ~we_i;
            rdata_q  <= rd_d;
        end
    end

    always_comb begin
        rvalid_o = rvalid_q;
        rdata_o  = rdata_q;
    end

endmodule

// File: rtl/spinlock_bank_chk.sv
`timescale 1ns/1ps
module spinlock_bank_chk
    import spinlock_pkg::*;
#(
    parameter int unsigned NUM_LOCKS   = 32,
    parameter int unsigned NUM_MASTERS = 2,
    parameter int unsigned ADDR_W      = 12
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic [NUM_MASTERS-1:0]        req_i,
    input logic [NUM_MASTERS-1:0]        we_i,
    input logic [NUM_MASTERS*ADDR_W-1:0] addr_i,
    input logic [NUM_MASTERS*DATA_W-1:0] wdata_i,
    input logic [NUM_MASTERS-1:0]        gnt_o,
    input logic [NUM_MASTERS-1:0]        rvalid_o,
    input logic [DATA_W-1:0]             rdata_o,
    input logic [NUM_LOCKS-1:0]          held_i
);

    localparam int unsigned IDX_W  = $clog2(NUM_LOCKS);
    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] LO = WORD_W'(LOCK_BASE_WORD);
    localparam logic [WORD_W-1:0] HI = WORD_W'(LOCK_BASE_WORD + NUM_LOCKS);
    localparam logic [DATA_W-1:0] SIZE_VAL = {size_code(NUM_LOCKS), {(DATA_W-4){1'b0}}};

    logic [ADDR_W-1:0] c_addr;
    logic [DATA_W-1:0] c_wd;
    logic              c_we;
    logic              c_any;
    logic              c_lock;
    logic              c_lock_rd;
    logic              c_lock_clr;
    logic              c_size_rd;
    logic [IDX_W-1:0]  c_idx;

    always_comb begin
        c_addr = '0;
        c_wd   = '0;
        c_we   = 1'b0;
        for (int m = 0; m < NUM_MASTERS; m++) begin
            if (gnt_o[m]) begin
                c_addr = addr_i[m*ADDR_W +: ADDR_W];
                c_wd   = wdata_i[m*DATA_W +: DATA_W];
                c_we   = we_i[m];
            end
        end
        c_any      = |gnt_o;
        c_lock     = c_any && (c_addr[1:0] == 2'b00) &&
                     (c_addr[ADDR_W-1:2] >= LO) && (c_addr[ADDR_W-1:2] < HI);
        c_idx      = IDX_W'(c_addr[ADDR_W-1:2] - LO);
        c_lock_rd  = c_lock && !c_we;
        c_lock_clr = c_lock && c_we && (c_wd == '0);
        c_size_rd  = c_any && !c_we && (c_addr == '0);
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o)); // R8
    AST_GRANT_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i[0] |-> gnt_o[0]); // R8
    AST_GRANT_SOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|req_i) |-> (|gnt_o)); // R8
    AST_RESP_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (rvalid_o == $past(gnt_o & ~we_i))); // R9
    AST_TAKE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_lock_rd && !held_i[c_idx]) |=> (rdata_o == '0) && held_i[$past(c_idx)]); // R2
    AST_HELD_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_lock_rd && held_i[c_idx]) |=> (rdata_o == 32'd1) && held_i[$past(c_idx)]); // R3
    AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        c_lock_clr |=> !held_i[$past(c_idx)]); // R4
    AST_SIZE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        c_size_rd |=> (rdata_o == SIZE_VAL)); // R1
    AST_RESET_FREE: assert property (@(posedge clk_i)
        !rst_ni |=> (held_i == '0)); // R10

endmodule

bind spinlock_bank spinlock_bank_chk #(
    .NUM_LOCKS   (NUM_LOCKS),
    .NUM_MASTERS (NUM_MASTERS),
    .ADDR_W      (ADDR_W)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .gnt_o    (gnt_o),
    .rvalid_o (rvalid_o),
    .rdata_o  (rdata_o),
    .held_i   (lock_held)
);

// File: tb/spinlock_bank_tb.sv
`timescale 1ns/1ps
module spinlock_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  req = '0;
    logic [1:0]  we = '0;
    logic [11:0] addr_m [2];
    logic [31:0] wd_m [2];
    logic [23:0] addr;
    logic [63:0] wdata;
    logic [1:0]  gnt;
    logic [1:0]  rvalid;
    logic [31:0] rdata;

    int errors = 0;
    int total  = 0;
    bit done   = 1'b0;

    assign addr  = {addr_m[1], addr_m[0]};
    assign wdata = {wd_m[1], wd_m[0]};

    always #10 clk = ~clk;   // 20 ns period, 50 MHz

    spinlock_bank #(.NUM_LOCKS(32), .NUM_MASTERS(2), .ADDR_W(12)) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .req_i    (req),
        .we_i     (we),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .gnt_o    (gnt),
        .rvalid_o (rvalid),
        .rdata_o  (rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_access(input int m, input logic wr, input logic [11:0] a,
                             input logic [31:0] d, output logic [31:0] rd,
                             output logic [1:0] rv);
        @(negedge clk);
        req[m] = 1'b1; we[m] = wr; addr_m[m] = a; wd_m[m] = d;
        #1;
        while (!gnt[m]) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        rd = rdata; rv = rvalid;
        req[m] = 1'b0; we[m] = 1'b0;
    endtask

    task automatic rd_word(input int m, input logic [11:0] a, input logic [31:0] exp,
                           input string tag);
        logic [31:0] rd;
        logic [1:0]  rv;
        do_access(m, 1'b0, a, '0, rd, rv);
        chk(tag, rd, exp);
        chk({tag, " R9 rvalid"}, {30'd0, rv}, 32'd1 << m);
    endtask

    task automatic wr_word(input int m, input logic [11:0] a, input logic [31:0] d);
        logic [31:0] rd;
        logic [1:0]  rv;
        do_access(m, 1'b1, a, d, rd, rv);
        chk("R9 no rvalid on write", {30'd0, rv}, 32'd0);
    endtask

    function automatic logic [11:0] lock_addr(input int i);
        return 12'(32'h100 + 4 * i);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; total++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] model;
        addr_m[0] = '0; addr_m[1] = '0; wd_m[0] = '0; wd_m[1] = '0;
        repeat (3) @(negedge clk);
        chk("R9 reset rvalid", {30'd0, rvalid}, 32'd0);
        rst_n = 1'b1;

        // R1, R10: size word and empty map after reset
        rd_word(0, 12'h000, 32'h1000_0000, "R1 size word");
        rd_word(1, 12'h010, 32'h0, "R10 map after reset");

        // R2, R3, R5, R6: take every lock in turn
        model = '0;
        for (int i = 0; i < 32; i++) begin
            rd_word(0, lock_addr(i), 32'd0, "R2 take free lock");
            model[i] = 1'b1;
            rd_word(1, lock_addr(i), 32'd1, "R3 read held lock");
            wr_word(1, lock_addr(i), 32'(i + 1));
            rd_word(0, lock_addr(i), 32'd1, "R5 nonzero write ignored");
            rd_word(1, 12'h010, model, "R6 map progressive");
        end

        // R5: writes to status words
        wr_word(0, 12'h000, 32'h0);
        wr_word(1, 12'h010, 32'h0);
        rd_word(0, 12'h010, 32'hFFFF_FFFF, "R5 map write ignored");
        rd_word(1, 12'h000, 32'h1000_0000, "R5 size write ignored");

        // R4: release even locks
        for (int i = 0; i < 32; i += 2) begin
            wr_word(i % 2, lock_addr(i), 32'h0);
            model[i] = 1'b0;
        end
        rd_word(0, 12'h010, 32'hAAAA_AAAA, "R4 R6 map after even release");
        for (int i = 0; i < 32; i++) begin
            rd_word(1, lock_addr(i), (i % 2 == 1) ? 32'd1 : 32'd0, "R4 state after release");
        end
        for (int i = 0; i < 32; i++) wr_word(0, lock_addr(i), 32'h0);
        rd_word(0, 12'h010, 32'h0, "R4 map after full release");

        // R7: lock indices beyond the count, unmapped and misaligned offsets
        for (int i = 32; i < 64; i++) begin
            rd_word(0, lock_addr(i), 32'd0, "R7 index beyond count");
            rd_word(1, lock_addr(i), 32'd0, "R7 index beyond count again");
        end
        rd_word(0, 12'h004, 32'd0, "R7 unmapped 0x004");
        rd_word(0, 12'h008, 32'd0, "R7 unmapped 0x008");
        rd_word(1, 12'h0FC, 32'd0, "R7 unmapped 0x0FC");
        rd_word(1, 12'h200, 32'd0, "R7 unmapped 0x200");
        rd_word(0, 12'hFFC, 32'd0, "R7 unmapped 0xFFC");
        rd_word(0, 12'h101, 32'd0, "R7 misaligned lock 0");
        rd_word(1, 12'h012, 32'd0, "R7 misaligned map");
        rd_word(0, 12'h010, 32'h0, "R7 map unchanged");

        // R8: both masters read lock 5 in the same cycle
        @(negedge clk);
        addr_m[0] = lock_addr(5); addr_m[1] = lock_addr(5);
        we = 2'b00; req = 2'b11;
        #1 chk("R8 lowest index granted", {30'd0, gnt}, 32'd1);
        @(posedge clk); @(negedge clk);
        chk("R8 winner reads free", rdata, 32'd0);
        chk("R8 winner rvalid", {30'd0, rvalid}, 32'd1);
        req[0] = 1'b0;
        #1 chk("R8 second master granted next", {30'd0, gnt}, 32'd2);
        @(posedge clk); @(negedge clk);
        chk("R8 loser reads held", rdata, 32'd1);
        chk("R8 loser rvalid", {30'd0, rvalid}, 32'd2);
        req = 2'b00;

        // R10: reset with locks held
        rd_word(1, lock_addr(7), 32'd0, "R2 take lock 7");
        rd_word(0, 12'h010, 32'h0000_00A0, "R6 map locks 5 and 7");
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_word(0, 12'h010, 32'h0, "R10 map cleared by reset");
        rd_word(1, lock_addr(5), 32'd0, "R10 lock free after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

endmodule